// File: doc/BRIEF.md
# Self-Detecting Dual-Timing Host Bus Slave

This block is the host-side front end of a small peripheral with a 4-bit register bank. It lets the peripheral sit on either of two common microcontroller bus styles without a strap or a configuration pin. Every time chip select goes from high to low, the block samples the level of a shared strobe pin, `ds_rd_i`. That level sets the bus timing for the rest of the select window.

With a low level, the block uses direction-plus-strobe timing: `rw_wr_i` gives the direction and `ds_rd_i` is an active-high data strobe. With a high level, it uses split-strobe timing: `rw_wr_i` is an active-low write strobe and `ds_rd_i` is an active-low read strobe.

All bus pins are synchronized into the system clock. Only the first strobe after the select edge is honoured. The block turns that strobe into a single-cycle read or write pulse for the register bank, together with the latched register-select bit and, for writes, the latched data nibble. During a read it enables the data output driver for as long as the read strobe stays active.

Top module: `hostbus_adapt`

## Requirements
- R1: When chip select is seen to fall while `ds_rd_i` is low, `mode_o` becomes 0 (direction-plus-strobe timing) and holds until chip select has risen and fallen again.
- R2: When chip select is seen to fall while `ds_rd_i` is high, `mode_o` becomes 1 (split-strobe timing) and holds for that select window.
- R3: In mode 0, a rising `ds_rd_i` with `rw_wr_i` high gives exactly one `reg_rd` pulse. `data_oe` is then 1 and `data_o` equals `rd_data_i` until `ds_rd_i` falls.
- R4: In mode 0, a `ds_rd_i` pulse with `rw_wr_i` low gives exactly one `reg_wr` pulse at the strobe's falling edge. `wr_data` then holds the nibble present on `data_i` at that edge.
- R5: In mode 1, a falling `ds_rd_i` gives exactly one `reg_rd` pulse. `data_oe` is then 1 and `data_o` equals `rd_data_i` until `ds_rd_i` returns high.
- R6: In mode 1, a low pulse on `rw_wr_i` gives exactly one `reg_wr` pulse when `rw_wr_i` returns high. `wr_data` then holds the nibble on `data_i` at that rising edge.
- R7: Within one select window at most one access is performed. Any strobe after the first, whether read or write, gives no pulse.
- R8: If chip select is already low when reset is released and no falling edge has been seen, strobe activity produces no pulse and leaves `mode_o` unchanged.
- R9: `reg_sel` is latched from `rs_i` at the chip-select falling edge in mode 1 (multiplexed bus) and at the leading edge of the access strobe in mode 0.
- R10: Outside an active read strobe, `data_oe` is 0 and `data_o` is 0.
- R11: After reset, `mode_o`, `reg_wr`, `reg_rd` and `data_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| ds_rd_i | input | 1 | Data strobe (mode 0) or read strobe, active low (mode 1) |
| rw_wr_i | input | 1 | Direction, high = read (mode 0), or write strobe, active low (mode 1) |
| rs_i | input | 1 | Register-select bit |
| data_i | input | 4 | Data nibble from the host |
| rd_data_i | input | 4 | Read data from the register bank |
| data_o | output | 4 | Data nibble to the host pad |
| data_oe | output | 1 | Output enable for the data pad |
| mode_o | output | 1 | Latched bus timing: 0 direction-plus-strobe, 1 split-strobe |
| reg_rd | output | 1 | Single-cycle register read pulse |
| reg_wr | output | 1 | Single-cycle register write pulse |
| reg_sel | output | 1 | Latched register-select bit |
| wr_data | output | 4 | Latched write nibble |

## Verification
A wrongly latched mode shows up as a swapped strobe decode. In that case a write appears as a read, or no access happens at all, and this is visible on `reg_wr`/`reg_rd` three clocks after the strobe edge. A guard state that fails to block later strobes shows a second pulse within the same select window. Sampling at the wrong moment shows up as a `reg_sel` or `wr_data` value that belongs to a neighbouring bus phase, because the stimulus changes both `rs_i` and `data_i` right after the latch point. Random accesses in both modes, mixed with directed cases for a select held low from reset and for surplus strobes, cover all of these.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_RD    = 3'd2,
    ST_WR    = 3'd3,
    ST_DONE  = 3'd4
  } acc_state_e;

  localparam logic MODE_DIRSTB = 1'b0;
  localparam logic MODE_SPLIT  = 1'b1;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/hb_access_fsm.sv
module hb_access_fsm
  import hb_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          ds_s,
  input  logic          rw_s,
  input  logic          rs_s,
  input  logic [DW-1:0] d_s,
  output logic          mode_q,
  output logic          rd_pulse_q,
  output logic          wr_pulse_q,
  output logic          sel_q,
  output logic [DW-1:0] wdat_q,
  output logic          oe_q
);
  acc_state_e    state_q, state_d;
  logic          cs_q, ds_q, rw_q;
  logic          mode_d, sel_d, rd_pulse_d, wr_pulse_d, oe_d;
  logic [DW-1:0] wdat_d;
  logic          cs_fall;
  logic          rd_lead, wr_lead, rd_trail, wr_trail;

  // edge decode, choice of strobe meaning follows the latched mode
  always_comb begin
    cs_fall = cs_q & ~cs_s;
    if (mode_q == MODE_SPLIT) begin
      rd_lead  = ds_q & ~ds_s;
      rd_trail = ~ds_q & ds_s;
      wr_lead  = rw_q & ~rw_s;
      wr_trail = ~rw_q & rw_s;
    end else begin
      rd_lead  = ~ds_q & ds_s & rw_s;
      wr_lead  = ~ds_q & ds_s & ~rw_s;
      rd_trail = ds_q & ~ds_s;
      wr_trail = ds_q & ~ds_s;
    end
  end

  // next-state logic
  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    sel_d      = sel_q;
    wdat_d     = wdat_q;
    rd_pulse_d = 1'b0;
    wr_pulse_d = 1'b0;
    if (cs_s) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cs_fall) begin
            state_d = ST_ARMED;
            mode_d  = ds_s;
            if (ds_s == MODE_SPLIT) sel_d = rs_s;
          end
        end
        ST_ARMED: begin
          if (rd_lead) begin
            state_d    = ST_RD;
            rd_pulse_d = 1'b1;
            if (mode_q == MODE_DIRSTB) sel_d = rs_s;
          end else if (wr_lead) begin
            state_d = ST_WR;
            if (mode_q == MODE_DIRSTB) sel_d = rs_s;
          end
        end
        ST_RD: begin
          if (rd_trail) state_d = ST_DONE;
        end
        ST_WR: begin
          if (wr_trail) begin
            state_d    = ST_DONE;
            wr_pulse_d = 1'b1;
            wdat_d     = d_s;
          end
        end
        ST_DONE: state_d = ST_DONE;
        default: state_d = ST_IDLE;
      endcase
    end
    oe_d = (state_d == ST_RD);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cs_q       <= 1'b0;
      ds_q       <= 1'b0;
      rw_q       <= 1'b1;
      mode_q     <= MODE_DIRSTB;
      sel_q      <= 1'b0;
      wdat_q     <= '0;
      rd_pulse_q <= 1'b0;
      wr_pulse_q <= 1'b0;
      oe_q       <= 1'b0;
    end else begin
      state_q    <= state_d;
      cs_q       <= cs_s;
      ds_q       <= ds_s;
      rw_q       <= rw_s;
      mode_q     <= mode_d;
      sel_q      <= sel_d;
      wdat_q     <= wdat_d;
      rd_pulse_q <= rd_pulse_d;
      wr_pulse_q <= wr_pulse_d;
      oe_q       <= oe_d;
    end
  end

  AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_pulse_q && wr_pulse_q)); // R7
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_q |=> !wr_pulse_q); // R7
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse_q |=> !rd_pulse_q); // R7
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!rd_pulse_q && !wr_pulse_q)); // R8
  AST_MODE_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> ($past(cs_q) && !$past(cs_s))); // R1
  AST_OE_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> rd_pulse_q); // R3
  AST_OE_OFF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_q |-> !oe_q); // R10
endmodule

// File: rtl/hb_rd_drive.sv
module hb_rd_drive #(
  parameter int DW = 4
) (
  input  logic          oe,
  input  logic [DW-1:0] rdat,
  output logic [DW-1:0] dout
);
  for (genvar b = 0; b < DW; b++) begin : g_gate
    assign dout[b] = oe & rdat[b];
  end

  always_comb begin
    if (!oe) AST_DOUT_QUIET: assert (dout == '0); // R10
  end
endmodule

// File: rtl/hostbus_adapt.sv
module hostbus_adapt
  import hb_pkg::*;
#(
  parameter int DW      = 4,
  parameter int SYNC_ST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_i,
  input  logic          ds_rd_i,
  input  logic          rw_wr_i,
  input  logic          rs_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  output logic          mode_o,
  output logic          reg_rd,
  output logic          reg_wr,
  output logic          reg_sel,
  output logic [DW-1:0] wr_data
);
  localparam int SW = DW + 4;
  // bit order {cs, ds, rw, rs, data}; rw rests high, cs rests low so a
  // select held low through reset is never taken as a falling edge
  localparam logic [SW-1:0] SYNC_RST = SW'(1) << (DW + 1);

  logic [SW-1:0] raw, synced;
  logic          oe_int;

  assign raw = {cs_n_i, ds_rd_i, rw_wr_i, rs_i, data_i};

  hb_sync #(.W(SW), .STAGES(SYNC_ST), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (synced)
  );

  hb_access_fsm #(.DW(DW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (synced[DW+3]),
    .ds_s       (synced[DW+2]),
    .rw_s       (synced[DW+1]),
    .rs_s       (synced[DW]),
    .d_s        (synced[DW-1:0]),
    .mode_q     (mode_o),
    .rd_pulse_q (reg_rd),
    .wr_pulse_q (reg_wr),
    .sel_q      (reg_sel),
    .wdat_q     (wr_data),
    .oe_q       (oe_int)
  );

  hb_rd_drive #(.DW(DW)) u_drv (
    .oe   (oe_int),
    .rdat (rd_data_i),
    .dout (data_o)
  );

  assign data_oe = oe_int;
endmodule

// File: tb/sim_hostbus_adapt.sv
module sim_hostbus_adapt;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, ds_rd, rw_wr, rs;
  logic [3:0] din, rdat;
  logic [3:0] dout, wdat;
  logic       oe, mode, rd_p, wr_p, sel;

  int n_chk = 0, n_bad = 0;
  int wr_tot = 0, rd_tot = 0;
  logic [3:0] cap_wdat = 4'h0;
  logic       cap_sel = 1'b0;

  always #2 clk = ~clk;

  hostbus_adapt u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .ds_rd_i(ds_rd), .rw_wr_i(rw_wr),
    .rs_i(rs), .data_i(din), .rd_data_i(rdat), .data_o(dout), .data_oe(oe),
    .mode_o(mode), .reg_rd(rd_p), .reg_wr(wr_p), .reg_sel(sel), .wr_data(wdat)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_p) begin wr_tot <= wr_tot + 1; cap_wdat <= wdat; cap_sel <= sel; end
      if (rd_p) begin rd_tot <= rd_tot + 1; cap_sel <= sel; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int exp_wr(input bit is_wr);
    return is_wr ? 1 : 0;
  endfunction
  function automatic int exp_rd(input bit is_wr);
    return is_wr ? 0 : 1;
  endfunction
  function automatic logic [3:0] exp_dout(input bit drive, input logic [3:0] rv);
    return drive ? rv : 4'h0;
  endfunction

  task automatic access(input bit split, input bit is_wr, input bit rsv,
                        input logic [3:0] dv, input logic [3:0] rv, input bit extra);
    int w0, r0;
    cs_n = 1'b1; ds_rd = split; rw_wr = 1'b1; rdat = rv; din = ~dv;
    rs = split ? rsv : ~rsv;
    tick(4);
    cs_n = 1'b0;
    tick(4);
    chk(split ? "R2" : "R1", int'(mode), int'(split));
    rs = split ? ~rsv : rsv;
    if (!split) rw_wr = ~is_wr;
    tick(4);
    w0 = wr_tot; r0 = rd_tot;
    if (split) begin
      if (is_wr) rw_wr = 1'b0; else ds_rd = 1'b0;
    end else ds_rd = 1'b1;
    tick(2);
    rs = ~rsv; din = dv;
    tick(3);
    if (!is_wr) begin
      chk(split ? "R5" : "R3", int'(oe), 1);
      chk(split ? "R5" : "R3", int'(dout), int'(rv));
    end else begin
      chk("R10", int'(oe), 0);
    end
    if (split) begin rw_wr = 1'b1; ds_rd = 1'b1; end else ds_rd = 1'b0;
    tick(2);
    din = ~dv;
    tick(3);
    chk("R10", int'(oe), 0);
    chk("R10", int'(dout), int'(exp_dout(1'b0, rv)));
    if (extra) begin
      if (split) begin
        ds_rd = 1'b0; tick(4); ds_rd = 1'b1; tick(4);
        rw_wr = 1'b0; tick(4); rw_wr = 1'b1; tick(4);
      end else begin
        rw_wr = 1'b1; ds_rd = 1'b1; tick(4); ds_rd = 1'b0; tick(4);
        rw_wr = 1'b0; ds_rd = 1'b1; tick(4); ds_rd = 1'b0; tick(4);
      end
      chk("R7", int'(oe), 0);
    end
    chk(split ? "R2" : "R1", int'(mode), int'(split));
    cs_n = 1'b1;
    tick(4);
    chk(is_wr ? (split ? "R6" : "R4") : (split ? "R5" : "R3"), wr_tot - w0, exp_wr(is_wr));
    chk(extra ? "R7" : (split ? "R5" : "R3"), rd_tot - r0, exp_rd(is_wr));
    if (is_wr) chk(split ? "R6" : "R4", int'(cap_wdat), int'(dv));
    chk("R9", int'(cap_sel), int'(rsv));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int w0, r0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cs_n = 1'b0; ds_rd = 1'b1; rw_wr = 1'b1; rs = 1'b1;
    din = 4'h0; rdat = 4'h9;
    tick(3);
    chk("R11", int'(mode), 0);
    chk("R11", int'(rd_p), 0);
    chk("R11", int'(wr_p), 0);
    chk("R11", int'(oe), 0);
    rst_n = 1'b1;
    tick(4);
    // R8: select held low since reset, no falling edge seen
    w0 = wr_tot; r0 = rd_tot;
    ds_rd = 1'b0; tick(4); ds_rd = 1'b1; tick(4);
    rw_wr = 1'b0; tick(4); rw_wr = 1'b1; tick(4);
    chk("R8", wr_tot - w0, 0);
    chk("R8", rd_tot - r0, 0);
    chk("R8", int'(mode), 0);
    chk("R8", int'(oe), 0);
    // directed corner cases
    access(1'b0, 1'b0, 1'b1, 4'h3, 4'hA, 1'b1);
    access(1'b0, 1'b1, 1'b0, 4'hC, 4'h5, 1'b1);
    access(1'b1, 1'b0, 1'b0, 4'h7, 4'hF, 1'b1);
    access(1'b1, 1'b1, 1'b1, 4'hE, 4'h0, 1'b1);
    // random mix
    for (int i = 0; i < 60; i++) begin
      access(1'($urandom), 1'($urandom), 1'($urandom),
             4'($urandom), 4'($urandom), 1'($urandom));
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule